// File: doc/BRIEF.md
# Tile Control Element

This block is the small sequencer that sits beside one processing tile of a coarse-grained cipher array; a 4x4 array carries sixteen copies. It runs a short micro-program and moves the tile through the phases of a symmetric-cipher mapping. For a block cipher these are setup, a repeated round, then output. For a stream cipher they are key load, state warm-up, then keystream. Every cycle it emits an index into the tile's own store of operator configurations, so no array-wide configuration swap is ever needed.

The element reacts to its surroundings in two ways. Status bits tapped from the data path (for example clock-control bits) can choose between two configuration indices in the same cycle. Done lines from neighbouring elements can stall the program: while stalled, the tile's output-register enable stays low so a short path keeps its value until a longer partner path is finished. A handshake output lets neighbours wait on this tile in turn, so simple local programs combine into a larger control flow.

The states are IDLE (halted or just reset), RUN (executing the instruction at the program counter), WAIT (stalled on a neighbour) and DONE (program finished). The transitions are: IDLE to RUN when halt is low. RUN to RUN on advance or hold. RUN to WAIT when a wait instruction sees its neighbour line low. WAIT to RUN when that line rises. RUN or WAIT to DONE when a last-flagged instruction advances. Any state to IDLE while halt is high.

Top module: `tce_tile_ctrl`

## Requirements
- R1: A synchronous reset puts the element in IDLE with the program counter at 0. In IDLE, cfg_idx_o, phase_o, reg_en_o, nbr_sig_o and fin_o are all 0. After reset, with halt low, the instruction at address 0 executes one cycle after reset falls.
- R2: A program-memory write takes effect only when halt_i is high at the clock edge. A write with halt_i low leaves the stored program unchanged.
- R3: The instruction word is laid out as follows: bits [15:14] phase, [13:10] primary index A, [9:6] count or alternate index B, [5] wait flag, [4] branch flag, [3:2] select, [1] last flag, [0] signal flag. While a plain instruction executes, cfg_idx_o is A, phase_o is the phase field, nbr_sig_o is the signal flag and reg_en_o is 1.
- R4: A plain instruction with count N stays current for N+1 cycles (the counter is loaded on entry and decremented each round), then the next address executes.
- R5: A wait instruction keeps reg_en_o at 0 and holds the program counter while nbr_done_i[select] is 0. In the cycle it sees that line high, it still drives reg_en_o at 0, and the next instruction runs on the following cycle. Other neighbour lines have no effect.
- R6: A branch instruction drives cfg_idx_o to B when status_i[select] is 1 and to A when it is 0, in the same cycle. It lasts exactly one cycle.
- R7: When an instruction with the last flag advances, the element enters DONE: fin_o is 1, and all other outputs are 0 regardless of status_i and nbr_done_i. It stays there until halt_i rises.
- R8: halt_i high in any state gives IDLE with the program counter at 0 on the next cycle. When halt_i falls, the program restarts from address 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| halt_i | input | 1 | Halts the program and opens the program-memory write port |
| pm_we_i | input | 1 | Program-memory write strobe |
| pm_addr_i | input | AW | Program-memory write address |
| pm_wdata_i | input | 16 | Instruction word to store |
| status_i | input | 4 | Feedback bits from the tile data path |
| nbr_done_i | input | 4 | Done lines from neighbouring elements |
| cfg_idx_o | output | 4 | Index into the tile's local configuration store |
| phase_o | output | 2 | Phase code of the current instruction |
| reg_en_o | output | 1 | Enable for the tile's output register |
| nbr_sig_o | output | 1 | Handshake to neighbours |
| fin_o | output | 1 | Program finished |

## Verification
The bench builds the element with the default depth of sixteen instructions, so AW is 4. A six-instruction program then covers every instruction kind within a few dozen cycles. With that depth, the 2-bit select reaches every status and neighbour line, so the bench can show that an unselected neighbour line is ignored. The 4-bit count field gives a multi-cycle round without long runs. Halt, reset and a gated write are applied in mid-program and in DONE, to show the restart from address 0.

// File: rtl/tce_pkg.sv
package tce_pkg;
    localparam int INSTR_W = 16;
    localparam int CFG_W   = 4;
    localparam int PHASE_W = 2;
    localparam int SEL_W   = 2;
    localparam int NSTAT   = 1 << SEL_W;
    localparam int NNBR    = 1 << SEL_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } tce_state_e;

    // Field order is decoded by the sequencer (R3).
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [CFG_W-1:0]   cfg_a;
        logic [CFG_W-1:0]   cfg_b;
        logic               wait_f;
        logic               branch_f;
        logic [SEL_W-1:0]   sel;
        logic               last_f;
        logic               sig_f;
    } tce_instr_t;
endpackage

// File: rtl/tce_prog_mem.sv
module tce_prog_mem
    import tce_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic               clk_i,
    input  logic               halt_i,
    input  logic               we_i,
    input  logic [AW-1:0]      waddr_i,
    input  logic [INSTR_W-1:0] wdata_i,
    input  logic [AW-1:0]      raddr_i,
    output logic [INSTR_W-1:0] rdata_o
);
    logic [DEPTH-1:0][INSTR_W-1:0] store;
    logic [DEPTH-1:0]              row_we;

    // Row strobes: writes open only while halted (R2).
    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        assign row_we[g] = halt_i && we_i && (waddr_i == AW'(g));
    end

    always_ff @(posedge clk_i) begin
        for (int r = 0; r < DEPTH; r++) begin
            if (row_we[r]) store[r] <= wdata_i;
        end
    end

    assign rdata_o = store[raddr_i];

    assert_write_gated_R2: assert property (@(posedge clk_i)
        (we_i && !halt_i) |=> $stable(store));
endmodule

// File: rtl/tce_rep_counter.sv
module tce_rep_counter #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] rep_i,
    output logic         zero_o
);
    logic         fresh_q;
    logic [W-1:0] cnt_q;
    logic [W-1:0] remaining;

    // On entry the count comes straight from the instruction (R4).
    assign remaining = fresh_q ? rep_i : cnt_q;
    assign zero_o    = (remaining == '0);

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            fresh_q <= 1'b1;
            cnt_q   <= '0;
        end else if (en_i && !zero_o) begin
            fresh_q <= 1'b0;
            cnt_q   <= remaining - 1'b1;
        end
    end

    assert_step_down_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !clr_i && !zero_o) |=> (!fresh_q && cnt_q < $past(remaining)));
endmodule

// File: rtl/tce_tile_ctrl.sv
module tce_tile_ctrl
    import tce_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               halt_i,
    input  logic               pm_we_i,
    input  logic [AW-1:0]      pm_addr_i,
    input  logic [INSTR_W-1:0] pm_wdata_i,
    input  logic [NSTAT-1:0]   status_i,
    input  logic [NNBR-1:0]    nbr_done_i,
    output logic [CFG_W-1:0]   cfg_idx_o,
    output logic [PHASE_W-1:0] phase_o,
    output logic               reg_en_o,
    output logic               nbr_sig_o,
    output logic               fin_o
);
    tce_state_e         state_q, state_d;
    logic [AW-1:0]      pc_q;
    logic [INSTR_W-1:0] rdata;
    tce_instr_t         instr;
    logic               nbr_hit;
    logic               stat_hit;
    logic               cnt_zero;
    logic               cnt_en;
    logic               cnt_clr;
    logic [CFG_W-1:0]   rep_val;
    logic               advance;
    logic               executing;

    tce_prog_mem #(.DEPTH(DEPTH)) u_mem (
        .clk_i   (clk_i),
        .halt_i  (halt_i),
        .we_i    (pm_we_i),
        .waddr_i (pm_addr_i),
        .wdata_i (pm_wdata_i),
        .raddr_i (pc_q),
        .rdata_o (rdata)
    );

    assign instr     = tce_instr_t'(rdata);
    assign nbr_hit   = nbr_done_i[instr.sel];
    assign stat_hit  = status_i[instr.sel];
    assign executing = (state_q == ST_RUN) || (state_q == ST_WAIT);

    // Branch words reuse the count field as index B, so they never repeat (R6).
    assign rep_val = instr.branch_f ? '0 : instr.cfg_b;

    always_comb begin
        advance = 1'b0;
        unique case (state_q)
            ST_RUN:  advance = instr.wait_f ? nbr_hit : cnt_zero;
            ST_WAIT: advance = nbr_hit;
            ST_IDLE: advance = 1'b0;
            ST_DONE: advance = 1'b0;
        endcase
    end

    assign cnt_en  = (state_q == ST_RUN) && !instr.wait_f;
    assign cnt_clr = !executing || advance || halt_i;

    tce_rep_counter #(.W(CFG_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (cnt_clr),
        .en_i   (cnt_en),
        .rep_i  (rep_val),
        .zero_o (cnt_zero)
    );

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = ST_RUN;
            ST_RUN: begin
                if (instr.wait_f && !nbr_hit) state_d = ST_WAIT;
                else if (advance && instr.last_f) state_d = ST_DONE;
                else state_d = ST_RUN;
            end
            ST_WAIT: begin
                if (nbr_hit) state_d = instr.last_f ? ST_DONE : ST_RUN;
            end
            ST_DONE: state_d = ST_DONE;
        endcase
    end

    // State and program-counter register (R1, R8).
    always_ff @(posedge clk_i) begin
        if (rst_i || halt_i) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            if (executing && advance) pc_q <= pc_q + 1'b1;
        end
    end

    // Output decode.
    always_comb begin
        cfg_idx_o = '0;
        phase_o   = '0;
        reg_en_o  = 1'b0;
        nbr_sig_o = 1'b0;
        fin_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                cfg_idx_o = (instr.branch_f && stat_hit) ? instr.cfg_b : instr.cfg_a;
                phase_o   = instr.phase;
                reg_en_o  = !instr.wait_f;
                nbr_sig_o = instr.sig_f;
            end
            ST_WAIT: begin
                cfg_idx_o = instr.cfg_a;
                phase_o   = instr.phase;
                nbr_sig_o = instr.sig_f;
            end
            ST_DONE: fin_o = 1'b1;
        endcase
    end

    assert_reset_idle_R1: assert property (@(posedge clk_i)
        rst_i |=> (state_q == ST_IDLE && pc_q == '0 && !reg_en_o));

    assert_quiet_outside_run_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q != ST_RUN) |-> !reg_en_o);

    assert_round_hold_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_RUN && !instr.wait_f && !cnt_zero && !halt_i)
        |=> (state_q == ST_RUN && $stable(pc_q)));

    assert_wait_stall_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_WAIT && !nbr_hit && !halt_i) |=> ($stable(pc_q) && !reg_en_o));

    assert_branch_single_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_RUN && instr.branch_f && !instr.wait_f && !instr.last_f && !halt_i)
        |=> (pc_q == AW'($past(pc_q) + 1'b1)));

    assert_done_sticky_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_DONE && !halt_i) |=> (state_q == ST_DONE && fin_o));

    assert_halt_restart_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        halt_i |=> (state_q == ST_IDLE && pc_q == '0));
endmodule

// File: tb/tce_tile_ctrl_tb_top.sv
`timescale 1ns/1ps
module tce_tile_ctrl_tb_top;
    localparam int DEPTH = 16;
    localparam int AW = $clog2(DEPTH);
    localparam int NVEC = 14;

    logic        clk = 1'b0;
    logic        rst_i, halt_i, pm_we_i;
    logic [AW-1:0] pm_addr_i;
    logic [15:0] pm_wdata_i;
    logic [3:0]  status_i, nbr_done_i;
    logic [3:0]  cfg_idx_o;
    logic [1:0]  phase_o;
    logic        reg_en_o, nbr_sig_o, fin_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    tce_tile_ctrl #(.DEPTH(DEPTH)) dut_i (
        .clk_i(clk), .rst_i(rst_i), .halt_i(halt_i),
        .pm_we_i(pm_we_i), .pm_addr_i(pm_addr_i), .pm_wdata_i(pm_wdata_i),
        .status_i(status_i), .nbr_done_i(nbr_done_i),
        .cfg_idx_o(cfg_idx_o), .phase_o(phase_o), .reg_en_o(reg_en_o),
        .nbr_sig_o(nbr_sig_o), .fin_o(fin_o)
    );

    // Word layout of R3: phase, A, B/count, wait, branch, select, last, signal.
    function automatic logic [15:0] enc(input int ph, input int a, input int b,
                                        input int w, input int br, input int sel,
                                        input int last, input int sig);
        return {ph[1:0], a[3:0], b[3:0], w[0], br[0], sel[1:0], last[0], sig[0]};
    endfunction

    // {status, nbr_done, cfg, phase, en, sig, fin, req}
    localparam logic [20:0] VEC [NVEC] = '{
        {4'h0, 4'h0, 4'd1, 2'd0, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 plain word at address 0
        {4'h0, 4'h0, 4'd2, 2'd1, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 round 1 of 4
        {4'h0, 4'h0, 4'd2, 2'd1, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 round 2
        {4'h0, 4'h0, 4'd2, 2'd1, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 round 3
        {4'h0, 4'h0, 4'd2, 2'd1, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 round 4
        {4'h0, 4'h0, 4'd3, 2'd1, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 stall begins
        {4'h0, 4'h1, 4'd3, 2'd1, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 wrong line ignored
        {4'h0, 4'h4, 4'd3, 2'd1, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 release cycle
        {4'h2, 4'h0, 4'd5, 2'd1, 1'b1, 1'b0, 1'b0, 4'd6},  // R6 bit set -> B
        {4'h7, 4'h0, 4'd7, 2'd1, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 bit clear -> A
        {4'h0, 4'h0, 4'd6, 2'd2, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 output phase 1 of 2
        {4'h0, 4'h0, 4'd6, 2'd2, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 output phase 2 of 2
        {4'h0, 4'h0, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 finished
        {4'hF, 4'hF, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1, 4'd7}   // R7 inputs ignored
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input int req, input logic [3:0] cfg, input logic [1:0] ph,
                       input logic en, input logic sig, input logic fin);
        logic [8:0] got, exp;
        got = {cfg_idx_o, phase_o, reg_en_o, nbr_sig_o, fin_o};
        exp = {cfg, ph, en, sig, fin};
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got cfg=%0d ph=%0d en=%0b sig=%0b fin=%0b, expected cfg=%0d ph=%0d en=%0b sig=%0b fin=%0b",
                     req, got[8:5], got[4:3], got[2], got[1], got[0],
                     exp[8:5], exp[4:3], exp[2], exp[1], exp[0]);
        end
    endtask

    task automatic wr(input int addr, input logic [15:0] data);
        pm_we_i = 1'b1; pm_addr_i = AW'(addr); pm_wdata_i = data;
        tick();
        pm_we_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_i = 1'b1; halt_i = 1'b1; pm_we_i = 1'b0; pm_addr_i = '0;
        pm_wdata_i = '0; status_i = '0; nbr_done_i = '0;
        @(negedge clk);
        tick();
        chk(1, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0);   // R1 reset state
        rst_i = 1'b0;

        wr(0, enc(0, 1, 0, 0, 0, 0, 0, 1));
        wr(1, enc(1, 2, 3, 0, 0, 0, 0, 0));
        wr(2, enc(1, 3, 0, 1, 0, 2, 0, 0));
        wr(3, enc(1, 4, 5, 0, 1, 1, 0, 0));
        wr(4, enc(1, 7, 8, 0, 1, 3, 0, 1));
        wr(5, enc(2, 6, 1, 0, 0, 0, 1, 0));
        halt_i = 1'b0;
        tick();

        for (int i = 0; i < NVEC; i++) begin
            status_i   = VEC[i][20:17];
            nbr_done_i = VEC[i][16:13];
            #1;
            chk(int'(VEC[i][3:0]), VEC[i][12:9], VEC[i][8:7], VEC[i][6], VEC[i][5], VEC[i][4]);
            tick();
        end
        status_i = '0; nbr_done_i = '0;

        // R2: write with halt low is dropped
        wr(0, enc(3, 15, 0, 0, 0, 0, 0, 0));
        chk(7, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1);    // R7 still finished
        halt_i = 1'b1;
        tick();
        chk(8, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0);    // R8 halted
        halt_i = 1'b0;
        tick();
        chk(2, 4'd1, 2'd0, 1'b1, 1'b1, 1'b0);    // R2 old word at address 0
        tick();
        chk(4, 4'd2, 2'd1, 1'b1, 1'b0, 1'b0);    // R4 round word

        // R8: halt in mid-round, then R2 write while halted
        halt_i = 1'b1;
        tick();
        chk(8, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0);
        wr(0, enc(3, 9, 0, 0, 0, 0, 0, 0));
        halt_i = 1'b0;
        tick();
        chk(2, 4'd9, 2'd3, 1'b1, 1'b0, 1'b0);    // R2 new word, R8 restart at 0

        // R1: reset in mid-program
        tick();
        chk(4, 4'd2, 2'd1, 1'b1, 1'b0, 1'b0);
        rst_i = 1'b1;
        tick();
        chk(1, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0);
        rst_i = 1'b0;
        tick();
        chk(1, 4'd9, 2'd3, 1'b1, 1'b0, 1'b0);    // R1 restart from address 0

        // R5: neighbour already done, R6 with bit clear
        nbr_done_i = 4'h4;
        repeat (5) tick();
        chk(5, 4'd3, 2'd1, 1'b0, 1'b0, 1'b0);
        tick();
        nbr_done_i = '0;
        status_i = 4'hD;
        #1;
        chk(6, 4'd4, 2'd1, 1'b1, 1'b0, 1'b0);

        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule